// File: doc/BRIEF.md
# Dual-Side Register File with Cross-Side Read Stall

This block holds two register files, side A and side B, each with 32 registers of 32 bits. Every side serves a fixed group of unit read ports. A unit either reads its own side's file or, when its cross flag is raised, reads the other side's file. Each side has one shared cross bus into the opposite file, so every cross-flagged unit on a side receives the same value. Each side also has two write ports. Writes take effect at the clock edge.

The block compares every cross-bus read with the writes committed on the opposite side in the previous clock. If the register on the bus was written then, the block raises `stall` for one cycle. The issuer holds its request through that cycle and reissues it in the next one, and then receives the new contents. A read from a unit's own file never causes a stall. Two error flags per side report conflicts: two different registers requested on one cross bus, and two write ports aimed at the same register.

Top module: `rfx_dual_rf`

## Requirements
- R1: After reset every register of both files reads 0, `stall` is low and all four error flags are low.
- R2: A unit with its cross flag low gets, in the same cycle, the register of its own side named by its index.
- R3: A write becomes visible from the cycle after its clock edge. A read of the same register in the cycle of the write returns the previous contents.
- R4: When both write ports of a side are enabled for the same register, that side's write-error flag is high in that cycle, and port 1's data is stored.
- R5: A unit with its cross flag high gets the register of the opposite side named by its index.
- R6: `stall` is high in a cycle where a cross-flagged unit names a register of the opposite file that was written at the previous clock edge. `stall` stays low when only own-side reads are issued, including reads of registers written at the previous edge.
- R7: `stall` is never high in two consecutive cycles. A read reissued in the cycle after a stall does not stall and returns the register's current contents, including a write made during the stall cycle.
- R8: Several units of one side may name the same register through the cross flag. This raises no error, and all of them get that register's value.
- R9: If cross-flagged units of one side name different registers, that side's cross-error flag is high. The cross bus then carries the register of the lowest-numbered flagged unit, and every flagged unit of that side gets it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| a_src_idx | input | 3x5 | Source register index per side-A unit |
| a_src_xp | input | 3 | Cross flag per side-A unit (1 = read file B) |
| b_src_idx | input | 3x5 | Source register index per side-B unit |
| b_src_xp | input | 3 | Cross flag per side-B unit (1 = read file A) |
| a_wr_en | input | 2 | Write enables, file A ports 0 and 1 |
| a_wr_idx | input | 2x5 | Write register indices, file A |
| a_wr_data | input | 2x32 | Write data, file A |
| b_wr_en | input | 2 | Write enables, file B ports 0 and 1 |
| b_wr_idx | input | 2x5 | Write register indices, file B |
| b_wr_data | input | 2x32 | Write data, file B |
| a_op_data | output | 3x32 | Operand delivered to each side-A unit |
| b_op_data | output | 3x32 | Operand delivered to each side-B unit |
| stall | output | 1 | One-cycle cross-read hazard stall |
| a_xp_err | output | 1 | Side-A units named different cross registers |
| b_xp_err | output | 1 | Side-B units named different cross registers |
| a_wr_err | output | 1 | File A write ports collided on one register |
| b_wr_err | output | 1 | File B write ports collided on one register |

## Verification
The assertions assume that enables and flags are never unknown after reset. They also assume that the issuer honours a stall by holding the same read for one more cycle. The last-writer-wins check uses the highest port's index, so it assumes that port's index is a valid register. Every stimulus is a directed task. Each task drives all inputs at the falling edge, clears them back to idle between scenarios, and reissues the same cross read after every stall, so these assumptions hold throughout.

// File: rtl/rfx_pkg.sv
package rfx_pkg;

  typedef enum logic {
    SIDE_A = 1'b0,
    SIDE_B = 1'b1
  } side_e;

  function automatic side_e other_side(side_e s);
    return (s == SIDE_A) ? SIDE_B : SIDE_A;
  endfunction

endpackage

// File: rtl/rfx_bank.sv
module rfx_bank #(
  parameter int NREG = 32,
  parameter int DW   = 32,
  parameter int NLR  = 3,
  parameter int NWP  = 2,
  localparam int IW  = $clog2(NREG)
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [NWP-1:0]           wr_en,
  input  logic [NWP-1:0][IW-1:0]   wr_idx,
  input  logic [NWP-1:0][DW-1:0]   wr_data,
  input  logic [NLR-1:0][IW-1:0]   lrd_idx,
  output logic [NLR-1:0][DW-1:0]   lrd_data,
  input  logic [IW-1:0]            xrd_idx,
  output logic [DW-1:0]            xrd_data,
  output logic                     xrd_recent,
  output logic                     wr_clash
);

  logic [DW-1:0]   mem [NREG];
  logic [NREG-1:0] recent;
  logic [NREG-1:0] touch;

  // registers hit by this cycle's writes
  function automatic logic [NREG-1:0] touch_mask(logic [NWP-1:0] en,
                                                 logic [NWP-1:0][IW-1:0] idx);
    logic [NREG-1:0] m;
    m = '0;
    for (int p = 0; p < NWP; p++)
      if (en[p]) m[idx[p]] = 1'b1;
    return m;
  endfunction

  // any two enabled ports aimed at one register
  function automatic logic port_clash(logic [NWP-1:0] en,
                                      logic [NWP-1:0][IW-1:0] idx);
    logic c;
    c = 1'b0;
    for (int p = 0; p < NWP; p++)
      for (int q = p + 1; q < NWP; q++)
        if (en[p] && en[q] && idx[p] == idx[q]) c = 1'b1;
    return c;
  endfunction

  assign touch    = touch_mask(wr_en, wr_idx);
  assign wr_clash = port_clash(wr_en, wr_idx);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int r = 0; r < NREG; r++) mem[r] <= '0;
      recent <= '0;
    end else begin
      // ascending order: the highest port is applied last and wins
      for (int p = 0; p < NWP; p++)
        if (wr_en[p]) mem[wr_idx[p]] <= wr_data[p];
      recent <= touch;
    end
  end

  always_comb begin
    for (int i = 0; i < NLR; i++) lrd_data[i] = mem[lrd_idx[i]];
  end

  assign xrd_data   = mem[xrd_idx];
  assign xrd_recent = recent[xrd_idx];

  // R4
  last_port_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en[NWP-1] |=> (mem[$past(wr_idx[NWP-1])] == $past(wr_data[NWP-1])));

  // R6
  recent_marked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en[0] |=> recent[$past(wr_idx[0])]);

endmodule

// File: rtl/rfx_xsel.sv
module rfx_xsel #(
  parameter int NREG = 32,
  parameter int NU   = 3,
  localparam int IW  = $clog2(NREG)
) (
  input  logic [NU-1:0][IW-1:0] src_idx,
  input  logic [NU-1:0]         src_xp,
  output logic [IW-1:0]         bus_idx,
  output logic                  bus_used,
  output logic                  multi_err
);

  // index carried by the lowest-numbered flagged unit
  function automatic logic [IW-1:0] first_flagged(logic [NU-1:0][IW-1:0] idx,
                                                  logic [NU-1:0] xp);
    logic [IW-1:0] r;
    logic          found;
    r     = '0;
    found = 1'b0;
    for (int u = 0; u < NU; u++)
      if (xp[u] && !found) begin
        r     = idx[u];
        found = 1'b1;
      end
    return r;
  endfunction

  function automatic logic disagree(logic [NU-1:0][IW-1:0] idx,
                                    logic [NU-1:0] xp, logic [IW-1:0] pick);
    logic d;
    d = 1'b0;
    for (int u = 0; u < NU; u++)
      if (xp[u] && idx[u] != pick) d = 1'b1;
    return d;
  endfunction

  assign bus_idx   = first_flagged(src_idx, src_xp);
  assign bus_used  = |src_xp;
  assign multi_err = disagree(src_idx, src_xp, bus_idx);

  // R9
  always_comb begin
    if (multi_err) begin
      multi_needs_two_chk: assert ($countones(src_xp) >= 2);
    end
  end

endmodule

// File: rtl/rfx_dual_rf.sv
module rfx_dual_rf
  import rfx_pkg::*;
#(
  parameter int NREG = 32,
  parameter int DW   = 32,
  parameter int NU   = 3,
  parameter int NWP  = 2,
  localparam int IW  = $clog2(NREG)
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [NU-1:0][IW-1:0]  a_src_idx,
  input  logic [NU-1:0]          a_src_xp,
  input  logic [NU-1:0][IW-1:0]  b_src_idx,
  input  logic [NU-1:0]          b_src_xp,
  input  logic [NWP-1:0]         a_wr_en,
  input  logic [NWP-1:0][IW-1:0] a_wr_idx,
  input  logic [NWP-1:0][DW-1:0] a_wr_data,
  input  logic [NWP-1:0]         b_wr_en,
  input  logic [NWP-1:0][IW-1:0] b_wr_idx,
  input  logic [NWP-1:0][DW-1:0] b_wr_data,
  output logic [NU-1:0][DW-1:0]  a_op_data,
  output logic [NU-1:0][DW-1:0]  b_op_data,
  output logic                   stall,
  output logic                   a_xp_err,
  output logic                   b_xp_err,
  output logic                   a_wr_err,
  output logic                   b_wr_err
);

  logic [NU-1:0][IW-1:0]  s_idx   [2];
  logic [NU-1:0]          s_xp    [2];
  logic [NWP-1:0]         w_en    [2];
  logic [NWP-1:0][IW-1:0] w_idx   [2];
  logic [NWP-1:0][DW-1:0] w_dat   [2];
  logic [NU-1:0][DW-1:0]  l_dat   [2];
  logic [NU-1:0][DW-1:0]  o_dat   [2];
  logic [IW-1:0]          bus_idx [2];
  logic [DW-1:0]          xdat    [2];
  logic                   bus_used[2];
  logic                   multi   [2];
  logic                   clash   [2];
  logic                   recent  [2];
  logic                   hit     [2];
  logic                   xp_hazard;
  logic                   stall_q;

  assign s_idx[0] = a_src_idx;  assign s_idx[1] = b_src_idx;
  assign s_xp[0]  = a_src_xp;   assign s_xp[1]  = b_src_xp;
  assign w_en[0]  = a_wr_en;    assign w_en[1]  = b_wr_en;
  assign w_idx[0] = a_wr_idx;   assign w_idx[1] = b_wr_idx;
  assign w_dat[0] = a_wr_data;  assign w_dat[1] = b_wr_data;

  for (genvar s = 0; s < 2; s++) begin : g_side
    localparam side_e ME = side_e'(s);
    localparam int    OS = int'(other_side(ME));

    // bank s serves its own units locally and side OS through its cross port
    rfx_bank #(.NREG(NREG), .DW(DW), .NLR(NU), .NWP(NWP)) bank_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr_en     (w_en[s]),
      .wr_idx    (w_idx[s]),
      .wr_data   (w_dat[s]),
      .lrd_idx   (s_idx[s]),
      .lrd_data  (l_dat[s]),
      .xrd_idx   (bus_idx[OS]),
      .xrd_data  (xdat[s]),
      .xrd_recent(recent[s]),
      .wr_clash  (clash[s])
    );

    rfx_xsel #(.NREG(NREG), .NU(NU)) xsel_i (
      .src_idx  (s_idx[s]),
      .src_xp   (s_xp[s]),
      .bus_idx  (bus_idx[s]),
      .bus_used (bus_used[s]),
      .multi_err(multi[s])
    );

    assign hit[s] = bus_used[s] & recent[OS];

    for (genvar u = 0; u < NU; u++) begin : g_unit
      assign o_dat[s][u] = s_xp[s][u] ? xdat[OS] : l_dat[s][u];
    end
  end

  assign xp_hazard = hit[0] | hit[1];
  // the reissued read after a stall is granted unconditionally
  assign stall     = xp_hazard & ~stall_q;

  always_ff @(posedge clk) begin
    if (!rst_n) stall_q <= 1'b0;
    else        stall_q <= stall;
  end

  assign a_op_data = o_dat[0];
  assign b_op_data = o_dat[1];
  assign a_xp_err  = multi[0];
  assign b_xp_err  = multi[1];
  assign a_wr_err  = clash[0];
  assign b_wr_err  = clash[1];

  // R6
  local_never_stalls_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!(|a_src_xp) && !(|b_src_xp)) |-> !stall);

  // R7
  stall_single_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stall |=> !stall);

endmodule

// File: tb/rfx_dual_rf_tb_top.sv
`timescale 1ns/1ps
module rfx_dual_rf_tb_top;

  logic                clk = 1'b0;
  logic                rst_n = 1'b0;
  logic [2:0][4:0]     a_src_idx = '0, b_src_idx = '0;
  logic [2:0]          a_src_xp = '0, b_src_xp = '0;
  logic [1:0]          a_wr_en = '0, b_wr_en = '0;
  logic [1:0][4:0]     a_wr_idx = '0, b_wr_idx = '0;
  logic [1:0][31:0]    a_wr_data = '0, b_wr_data = '0;
  logic [2:0][31:0]    a_op_data, b_op_data;
  logic                stall, a_xp_err, b_xp_err, a_wr_err, b_wr_err;

  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  rfx_dual_rf dut_i (
    .clk(clk), .rst_n(rst_n),
    .a_src_idx(a_src_idx), .a_src_xp(a_src_xp),
    .b_src_idx(b_src_idx), .b_src_xp(b_src_xp),
    .a_wr_en(a_wr_en), .a_wr_idx(a_wr_idx), .a_wr_data(a_wr_data),
    .b_wr_en(b_wr_en), .b_wr_idx(b_wr_idx), .b_wr_data(b_wr_data),
    .a_op_data(a_op_data), .b_op_data(b_op_data), .stall(stall),
    .a_xp_err(a_xp_err), .b_xp_err(b_xp_err),
    .a_wr_err(a_wr_err), .b_wr_err(b_wr_err)
  );

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic clear_inputs();
    a_src_idx = '0; b_src_idx = '0; a_src_xp = '0; b_src_xp = '0;
    a_wr_en = '0; b_wr_en = '0; a_wr_idx = '0; b_wr_idx = '0;
    a_wr_data = '0; b_wr_data = '0;
  endtask

  // one full cycle of idle inputs, leaving no recent writes or stall behind
  task automatic idle_cycle();
    @(negedge clk);
    clear_inputs();
  endtask

  task automatic t_reset();
    @(negedge clk);
    clear_inputs();
    a_src_idx[1] = 5'd31; b_src_idx[2] = 5'd17;
    #1;
    chk("R1 a unit1", a_op_data[1], 32'h0);
    chk("R1 b unit2", b_op_data[2], 32'h0);
    chk("R1 stall", {31'b0, stall}, 32'h0);
    chk("R1 flags", {28'b0, a_xp_err, b_xp_err, a_wr_err, b_wr_err}, 32'h0);
  endtask

  task automatic t_local();
    idle_cycle();
    @(negedge clk);
    a_wr_en = 2'b01; a_wr_idx[0] = 5'd5; a_wr_data[0] = 32'hA5A5_0005;
    b_wr_en = 2'b10; b_wr_idx[1] = 5'd5; b_wr_data[1] = 32'h5B5B_0005;
    @(negedge clk);
    clear_inputs();
    a_src_idx[0] = 5'd5; b_src_idx[2] = 5'd5;
    #1;
    chk("R2 a local", a_op_data[0], 32'hA5A5_0005);
    chk("R2 b local", b_op_data[2], 32'h5B5B_0005);
    chk("R6 local no stall", {31'b0, stall}, 32'h0);
  endtask

  task automatic t_same_cycle();
    idle_cycle();
    @(negedge clk);
    a_wr_en = 2'b01; a_wr_idx[0] = 5'd7; a_wr_data[0] = 32'h7777_0001;
    a_src_idx[0] = 5'd7;
    #1;
    chk("R3 old before first write", a_op_data[0], 32'h0);
    @(negedge clk);
    a_wr_data[0] = 32'h7777_0002;
    #1;
    chk("R3 old during second write", a_op_data[0], 32'h7777_0001);
    @(negedge clk);
    a_wr_en = '0;
    #1;
    chk("R3 new after write", a_op_data[0], 32'h7777_0002);
  endtask

  task automatic t_clash();
    idle_cycle();
    @(negedge clk);
    a_wr_en = 2'b11;
    a_wr_idx[0] = 5'd9; a_wr_data[0] = 32'h1111_1111;
    a_wr_idx[1] = 5'd9; a_wr_data[1] = 32'h2222_2222;
    #1;
    chk("R4 a_wr_err", {31'b0, a_wr_err}, 32'h1);
    chk("R4 b_wr_err", {31'b0, b_wr_err}, 32'h0);
    @(negedge clk);
    clear_inputs();
    a_src_idx[2] = 5'd9;
    #1;
    chk("R4 port1 wins", a_op_data[2], 32'h2222_2222);
    chk("R4 flag clears", {31'b0, a_wr_err}, 32'h0);
  endtask

  task automatic t_xp_nostall();
    idle_cycle();
    @(negedge clk);
    b_wr_en = 2'b01; b_wr_idx[0] = 5'd4; b_wr_data[0] = 32'h4444_0004;
    a_wr_en = 2'b01; a_wr_idx[0] = 5'd2; a_wr_data[0] = 32'h2222_0002;
    @(negedge clk);
    clear_inputs();
    a_src_idx[0] = 5'd2;
    #1;
    chk("R6 local read of fresh reg", {31'b0, stall}, 32'h0);
    chk("R2 fresh local data", a_op_data[0], 32'h2222_0002);
    @(negedge clk);
    clear_inputs();
    a_src_xp[2] = 1'b1; a_src_idx[2] = 5'd4;
    #1;
    chk("R6 old cross no stall", {31'b0, stall}, 32'h0);
    chk("R5 cross data a<-b", a_op_data[2], 32'h4444_0004);
  endtask

  task automatic t_xp_stall();
    idle_cycle();
    @(negedge clk);
    b_wr_en = 2'b01; b_wr_idx[0] = 5'd3; b_wr_data[0] = 32'hB0B0_0003;
    @(negedge clk);
    clear_inputs();
    a_src_xp[1] = 1'b1; a_src_idx[1] = 5'd3;
    #1;
    chk("R6 stall on fresh cross", {31'b0, stall}, 32'h1);
    @(negedge clk);
    #1;
    chk("R7 reissue no stall", {31'b0, stall}, 32'h0);
    chk("R7 reissue data", a_op_data[1], 32'hB0B0_0003);
  endtask

  task automatic t_back_to_back();
    idle_cycle();
    @(negedge clk);
    a_wr_en = 2'b10; a_wr_idx[1] = 5'd12; a_wr_data[1] = 32'hC0DE_0001;
    @(negedge clk);
    clear_inputs();
    b_src_xp[0] = 1'b1; b_src_idx[0] = 5'd12;
    a_wr_en = 2'b10; a_wr_idx[1] = 5'd12; a_wr_data[1] = 32'hC0DE_0002;
    #1;
    chk("R6 stall b<-a", {31'b0, stall}, 32'h1);
    @(negedge clk);
    a_wr_en = '0;
    #1;
    chk("R7 no second stall", {31'b0, stall}, 32'h0);
    chk("R7 latest data", b_op_data[0], 32'hC0DE_0002);
  endtask

  task automatic t_share();
    idle_cycle();
    @(negedge clk);
    a_wr_en = 2'b01; a_wr_idx[0] = 5'd6; a_wr_data[0] = 32'h6666_0006;
    idle_cycle();
    @(negedge clk);
    clear_inputs();
    a_src_xp = 3'b101; a_src_idx[0] = 5'd3; a_src_idx[2] = 5'd3;
    a_src_idx[1] = 5'd6;
    b_src_xp[1] = 1'b1; b_src_idx[1] = 5'd6;
    #1;
    chk("R8 unit0 shared", a_op_data[0], 32'hB0B0_0003);
    chk("R8 unit2 shared", a_op_data[2], 32'hB0B0_0003);
    chk("R8 no error", {30'b0, a_xp_err, b_xp_err}, 32'h0);
    chk("R2 local beside cross", a_op_data[1], 32'h6666_0006);
    chk("R5 cross data b<-a", b_op_data[1], 32'h6666_0006);
  endtask

  task automatic t_multi();
    idle_cycle();
    @(negedge clk);
    a_src_xp = 3'b011; a_src_idx[0] = 5'd4; a_src_idx[1] = 5'd3;
    #1;
    chk("R9 a_xp_err", {31'b0, a_xp_err}, 32'h1);
    chk("R9 b_xp_err", {31'b0, b_xp_err}, 32'h0);
    chk("R9 lowest unit wins u0", a_op_data[0], 32'h4444_0004);
    chk("R9 lowest unit wins u1", a_op_data[1], 32'h4444_0004);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_local();
    t_same_cycle();
    t_clash();
    t_xp_nostall();
    t_xp_stall();
    t_back_to_back();
    t_share();
    t_multi();
    idle_cycle();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule